// File: doc/BRIEF.md
# Byte-Serial Modulo-15 Word Checker

This block watches a 4-bit data bus that carries 32-bit words as eight consecutive nibbles. It checks each word for code errors while the word passes. It is placed beside the bus and needs no handshake, because it only observes. A nibble counts when `nib_vld` is high. The first nibble of a word is marked by `nib_sow`, and `nib_instr` says whether the word is a plain arithmetic-coded word or an instruction word.

For an arithmetic-coded word, every nibble is added into a 4-bit ones'-complement accumulator whose carry out wraps back into bit 0. The accumulator starts at 1111, which is this arithmetic's form of zero. Because 16 leaves a remainder of 1 when divided by 15, the final accumulator equals the word's residue modulo 15. A word is good only when the accumulator ends at 1111. In an instruction word, the first three nibbles are an opcode and stay out of the sum. Each of them must have exactly two bits set, which gives six legal patterns per nibble. The remaining five nibbles hold the address and its check symbol, and they are summed as above.

The controller has three states. IDLE waits for a start nibble. OPCODE takes the opcode nibbles of an instruction word. SUM takes the nibbles that are summed. The transitions are:
- IDLE→OPCODE on the start nibble of an instruction word.
- IDLE→SUM on the start nibble of a data word.
- OPCODE→SUM after the last opcode nibble.
- SUM→IDLE after nibble 7, which raises the done strobe.
- A start nibble in OPCODE or SUM restarts the word, going to OPCODE or SUM.

Top module: `mod15_bus_checker`

## Requirements
- R1: While reset is asserted and after its release, `chk_done`, `arith_err` and `opc_err` are low, and the checker waits for a start nibble.
- R2: A word is eight accepted nibbles, and a nibble is accepted in a cycle where `nib_vld` is high. Nibble 0 is the one that carries `nib_sow`, and it is bits 31:28 of the word. Later nibbles follow from high bits to low bits.
- R3: For a data word (`nib_instr`=0 at the start), `arith_err` is 1 exactly when the sum of all eight nibbles is not a multiple of 15. An all-zero word and an all-ones word are both good.
- R4: For an instruction word (`nib_instr`=1 at the start), nibbles 0 to 2 are left out of the sum, and `arith_err` is 1 exactly when the sum of nibbles 3 to 7 is not a multiple of 15.
- R5: For an instruction word, `opc_err` is 1 exactly when any of nibbles 0 to 2 has a number of set bits other than two. For a data word, `opc_err` is always 0.
- R6: `chk_done` is high for exactly one cycle, which is the cycle after the clock edge that accepts nibble 7. The error outputs for the word are valid in that same cycle.
- R7: `arith_err` and `opc_err` are low in every cycle in which `chk_done` is low.
- R8: A nibble with `nib_vld` high and `nib_sow` low, arriving while no word is open, is ignored and produces no `chk_done`.
- R9: A start nibble arriving in the middle of a word abandons that word without any `chk_done` for it. Counting restarts with the start nibble as nibble 0.
- R10: `nib_instr` is sampled only together with the start nibble. Changes to it later in the word have no effect.
- R11: Cycles with `nib_vld` low inside a word are idle gaps and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_vld | input | 1 | A nibble is present on `nib_data` |
| nib_sow | input | 1 | This nibble is nibble 0 of a word |
| nib_instr | input | 1 | Word type at start: 1 instruction, 0 data |
| nib_data | input | 4 | Nibble value |
| chk_done | output | 1 | One-cycle strobe: word check finished |
| arith_err | output | 1 | Modulo-15 residue of the summed nibbles is not zero |
| opc_err | output | 1 | An opcode nibble is not two-of-four |

## Verification
The assertions take for granted that the inputs are known after reset, and that `nib_sow` only means something when `nib_vld` is high. They also assume that a word that is never finished simply leaves the checker waiting, with no timeout. The stimulus raises `nib_sow` only on the first nibble of a word, changes `nib_data` and the qualifiers on the falling clock edge, and always completes a word unless it is testing an abandoned word. Random words use a fixed seed. They mix legal and illegal opcode patterns, last nibbles chosen to land the residue on zero, random idle gaps, and word-type toggles after the start nibble.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPCODE = 2'd1,
        ST_SUM    = 2'd2
    } mbc_state_e;

endpackage

// File: rtl/mbc_eac_add.sv
module mbc_eac_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] add_a,
    input  logic [W-1:0] add_b,
    output logic [W-1:0] add_s
);

    logic [W:0] raw_sum;

    always_comb begin
        raw_sum = {1'b0, add_a} + {1'b0, add_b};
        add_s   = raw_sum[W-1:0] + W'(raw_sum[W]);
    end

endmodule

// File: rtl/mbc_mofn.sv
module mbc_mofn #(
    parameter int W = 4,
    parameter int M = 2
) (
    input  logic [W-1:0] sym_in,
    output logic         sym_ok
);

    localparam int CNT_W = $clog2(W + 1);

    logic [CNT_W-1:0] ones_cnt;

    always_comb begin
        ones_cnt = '0;
        for (int i = 0; i < W; i++) begin
            ones_cnt = ones_cnt + CNT_W'(sym_in[i]);
        end
        sym_ok = (ones_cnt == CNT_W'(M));
    end

endmodule

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
    import mbc_pkg::*;
#(
    parameter int NIB_W     = 4,
    parameter int WORD_NIBS = 8,
    parameter int OPC_NIBS  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_vld,
    input  logic             nib_sow,
    input  logic             nib_instr,
    input  logic [NIB_W-1:0] sum_in,
    input  logic             sym_ok,
    output logic [NIB_W-1:0] acc_src,
    output logic             chk_done,
    output logic             arith_err,
    output logic             opc_err
);

    localparam int IDX_W     = $clog2(WORD_NIBS);
    localparam int LAST_IDX  = WORD_NIBS - 1;
    localparam int LAST_OPC  = OPC_NIBS - 1;
    localparam logic [NIB_W-1:0] ONES_ZERO = '1;

    mbc_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [NIB_W-1:0] acc_q, acc_d;
    logic             opc_bad_q, opc_bad_d;
    logic             instr_q, instr_d;
    logic             start;
    logic             finish;

    assign start   = nib_vld && nib_sow;
    assign acc_src = start ? ONES_ZERO : acc_q;

    // next-state and datapath
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        acc_d     = acc_q;
        opc_bad_d = opc_bad_q;
        instr_d   = instr_q;
        finish    = 1'b0;
        if (start) begin
            idx_d   = IDX_W'(1);
            instr_d = nib_instr;
            if (nib_instr) begin
                acc_d     = ONES_ZERO;
                opc_bad_d = !sym_ok;
                state_d   = (OPC_NIBS > 1) ? ST_OPCODE : ST_SUM;
            end else begin
                acc_d     = sum_in;
                opc_bad_d = 1'b0;
                state_d   = ST_SUM;
            end
        end else if (nib_vld) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_OPCODE: begin
                    opc_bad_d = opc_bad_q || !sym_ok;
                    idx_d     = idx_q + IDX_W'(1);
                    if (idx_q == IDX_W'(LAST_OPC)) begin
                        state_d = ST_SUM;
                    end
                end
                ST_SUM: begin
                    acc_d = sum_in;
                    if (idx_q == IDX_W'(LAST_IDX)) begin
                        finish  = 1'b1;
                        idx_d   = '0;
                        state_d = ST_IDLE;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            acc_q     <= ONES_ZERO;
            opc_bad_q <= 1'b0;
            instr_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            idx_q     <= idx_d;
            acc_q     <= acc_d;
            opc_bad_q <= opc_bad_d;
            instr_q   <= instr_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_done  <= 1'b0;
            arith_err <= 1'b0;
            opc_err   <= 1'b0;
        end else begin
            chk_done  <= finish;
            arith_err <= finish && (sum_in != ONES_ZERO);
            opc_err   <= finish && opc_bad_q;
        end
    end

    AST_ACC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (acc_q != '0)); // R3
    AST_OPC_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPCODE) |-> (instr_q && (idx_q < IDX_W'(OPC_NIBS)))); // R4
    AST_DATA_NO_OPC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUM && !instr_q) |-> !opc_bad_q); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |=> !chk_done); // R6
    AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_done |-> (!arith_err && !opc_err)); // R7
    AST_DONE_AFTER_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> $past(nib_vld && !nib_sow)); // R2
    AST_IDLE_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && nib_vld && !nib_sow) |=> !chk_done); // R8
    AST_RESTART_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> !chk_done); // R9

endmodule

// File: rtl/mod15_bus_checker.sv
module mod15_bus_checker #(
    parameter int NIB_W     = 4,
    parameter int WORD_NIBS = 8,
    parameter int OPC_NIBS  = 3,
    parameter int OPC_ONES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_vld,
    input  logic             nib_sow,
    input  logic             nib_instr,
    input  logic [NIB_W-1:0] nib_data,
    output logic             chk_done,
    output logic             arith_err,
    output logic             opc_err
);

    logic [NIB_W-1:0] acc_src;
    logic [NIB_W-1:0] sum_w;
    logic             sym_ok;

    mbc_eac_add #(.W(NIB_W)) u_add (
        .add_a (acc_src),
        .add_b (nib_data),
        .add_s (sum_w)
    );

    mbc_mofn #(.W(NIB_W), .M(OPC_ONES)) u_mofn (
        .sym_in (nib_data),
        .sym_ok (sym_ok)
    );

    mbc_ctrl #(
        .NIB_W     (NIB_W),
        .WORD_NIBS (WORD_NIBS),
        .OPC_NIBS  (OPC_NIBS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_vld   (nib_vld),
        .nib_sow   (nib_sow),
        .nib_instr (nib_instr),
        .sum_in    (sum_w),
        .sym_ok    (sym_ok),
        .acc_src   (acc_src),
        .chk_done  (chk_done),
        .arith_err (arith_err),
        .opc_err   (opc_err)
    );

endmodule

// File: tb/mod15_bus_checker_tb_top.sv
`timescale 1ns/1ps
module mod15_bus_checker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_vld = 1'b0;
    logic       nib_sow = 1'b0;
    logic       nib_instr = 1'b0;
    logic [3:0] nib_data = 4'h0;
    logic       chk_done;
    logic       arith_err;
    logic       opc_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mod15_bus_checker dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_vld   (nib_vld),
        .nib_sow   (nib_sow),
        .nib_instr (nib_instr),
        .nib_data  (nib_data),
        .chk_done  (chk_done),
        .arith_err (arith_err),
        .opc_err   (opc_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] nib_of(input logic [31:0] w, input int k);
        return w[31-4*k -: 4];
    endfunction

    function automatic bit exp_arith(input logic [31:0] w, input bit instr);
        int s = 0;
        for (int k = (instr ? 3 : 0); k < 8; k++) s += int'(nib_of(w, k));
        return (s % 15) != 0;
    endfunction

    function automatic bit exp_opc(input logic [31:0] w, input bit instr);
        bit bad = 1'b0;
        if (!instr) return 1'b0;
        for (int k = 0; k < 3; k++) if ($countones(nib_of(w, k)) != 2) bad = 1'b1;
        return bad;
    endfunction

    task automatic send_word(input logic [31:0] w, input bit instr, input int gapmax, input bit flip);
        for (int k = 0; k < 8; k++) begin
            if (gapmax > 0 && k > 0) begin
                int g = int'($urandom_range(gapmax, 0));
                for (int j = 0; j < g; j++) begin
                    nib_vld = 1'b0;
                    nib_sow = 1'b0;
                    nib_data = 4'($urandom);
                    @(negedge clk);
                    chk("R11 gap no done", 32'(chk_done), 0);
                end
            end
            nib_vld   = 1'b1;
            nib_sow   = (k == 0);
            nib_data  = nib_of(w, k);
            nib_instr = (k == 0) ? instr : (flip ? ~instr : instr);
            @(negedge clk);
            if (k < 7) chk("R6 no early done", 32'(chk_done), 0);
        end
        nib_vld = 1'b0;
        nib_sow = 1'b0;
        chk("R6 done strobe", 32'(chk_done), 1);
        chk(instr ? "R4 arith_err instr" : "R3 arith_err data", 32'(arith_err), 32'(exp_arith(w, instr)));
        chk("R5 opc_err", 32'(opc_err), 32'(exp_opc(w, instr)));
        @(negedge clk);
        chk("R6 done one cycle", 32'(chk_done), 0);
        chk("R7 errs low w/o done", 32'({arith_err, opc_err}), 0);
    endtask

    function automatic logic [31:0] make_word(input bit instr);
        logic [3:0] legal [6] = '{4'h3, 4'h5, 4'h6, 4'h9, 4'hA, 4'hC};
        logic [31:0] w = $urandom;
        int s = 0;
        if (instr) begin
            for (int k = 0; k < 3; k++)
                if ($urandom_range(9, 0) < 8) w[31-4*k -: 4] = legal[$urandom_range(5, 0)];
        end
        for (int k = (instr ? 3 : 0); k < 7; k++) s += int'(nib_of(w, k));
        if ($urandom_range(9, 0) < 7) begin
            int r = (15 - (s % 15)) % 15;
            if (r == 0 && $urandom_range(1, 0) == 1) r = 15;
            w[3:0] = 4'(r);
        end
        return w;
    endfunction

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk("R1 reset done", 32'(chk_done), 0);
        chk("R1 reset errs", 32'({arith_err, opc_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 32'({chk_done, arith_err, opc_err}), 0);

        // directed corner cases
        send_word(32'h0000_0000, 1'b0, 0, 1'b0);   // R3 zero word good
        send_word(32'hFFFF_FFFF, 1'b0, 0, 1'b0);   // R3 all ones good
        send_word(32'h0000_0001, 1'b0, 0, 1'b0);   // R3 residue 1
        send_word(32'h1234_5678, 1'b0, 0, 1'b0);   // R3 sum 36
        send_word(32'h3560_000F, 1'b1, 0, 1'b0);   // R4 R5 legal instr
        send_word(32'h7000_0000, 1'b1, 0, 1'b0);   // R5 three bits set
        send_word(32'h0000_0000, 1'b1, 0, 1'b0);   // R5 zero opcode
        send_word(32'h1110_0000, 1'b0, 0, 1'b0);   // R3 sum 3 as data
        send_word(32'hC9A1_0000, 1'b1, 0, 1'b0);   // R4 opcode excluded, addr residue 1
        send_word(32'hC9A0_0000, 1'b1, 2, 1'b1);   // R10 R11 type flip, gaps

        // R8 stray nibbles while idle
        for (int j = 0; j < 3; j++) begin
            nib_vld = 1'b1; nib_sow = 1'b0; nib_data = 4'h5;
            @(negedge clk);
            chk("R8 stray ignored", 32'(chk_done), 0);
        end
        nib_vld = 1'b0;
        @(negedge clk);
        chk("R8 stray ignored later", 32'(chk_done), 0);
        send_word(32'h5000_0001, 1'b0, 0, 1'b0);   // R8 stray did not offset count

        // R9 abandoned word
        for (int k = 0; k < 5; k++) begin
            nib_vld = 1'b1; nib_sow = (k == 0); nib_instr = 1'b1; nib_data = 4'h7;
            @(negedge clk);
            chk("R9 no done partial", 32'(chk_done), 0);
        end
        send_word(32'h0000_0000, 1'b0, 0, 1'b0);   // R9 restart clean

        // random words
        for (int i = 0; i < 300; i++) begin
            bit ins = 1'($urandom);
            send_word(make_word(ins), ins, int'($urandom_range(2, 0)), ($urandom_range(3, 0) == 0));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule